// File: doc/BRIEF.md
# Dual-Threshold Discriminator Back End

This block is the digital side of a sixteen-channel discriminator. Every channel has two comparators, one for a low and one for a high threshold, which gives 32 discriminated signals. Each signal is synchronized to the 250 MHz core clock. A rising edge starts an output pulse whose length is set in clock ticks, and the same edge advances a saturating scaler for that signal.

A bank of programmable outputs forms logic over the 32 shaped pulses. Each output has a 32-bit selection mask and a mode bit. The mode bit picks either an OR or an AND of the selected pulses.

A plain register port writes the settings and reads them back. Through the same port, software takes a snapshot of all scalers at once and clears them in the same cycle. Comparator inputs and pulse outputs are plain level pins with no handshake: an edge can never be refused, so the block applies no back-pressure anywhere.

Top module: `disc_dual_thr`

## Requirements
- R1: Signal index i runs over 0 to 31. The low threshold of channel c is index c and the high threshold is index 16+c. This index selects the bit in `pulse_out` and in every mask, and the scaler snapshot address 0x40+i.
- R2: A rising edge on a comparator input gives the first high cycle of `pulse_out[i]` after the third rising clock edge, counted from the edge that first samples the input high.
- R3: The pulse lasts exactly W clock cycles. W comes from bits [3:0] of register 0x00. A value below 2 acts as 2, a value above 10 acts as 10, and the reset value is 2.
- R4: A new rising edge that arrives while a pulse is active neither extends nor restarts that pulse.
- R5: Each scaler adds one for every synchronized rising edge of its signal, including edges that arrive during an active pulse.
- R6: A scaler that is at all-ones stays there instead of wrapping.
- R7: Writing bit 0 = 1 to address 0x01 copies all scalers to the snapshot bank and clears them in the same cycle. An edge that falls in that cycle counts as 1 in the new period.
- R8: Output k uses the mask at 0x10+k and mode bit k at 0x20. Mode 0 gives the OR of the masked pulses and mode 1 gives the AND. An empty mask always gives 0. `logic_out` follows `pulse_out` one cycle later.
- R9: A read strobe puts the addressed data on `bus_rdata` at the next clock edge. Unmapped addresses read 0.
- R10: After reset all pulses, logic outputs, masks, mode bits and scalers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_lo | input | NCH | Low-threshold comparator levels |
| cmp_hi | input | NCH | High-threshold comparator levels |
| pulse_out | output | 2*NCH | Shaped pulses, index per R1 |
| logic_out | output | NOUT | Programmable logic outputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
Single isolated edges are sent through both threshold indices of several channels, with the width register set below, inside and above its range. This separates the clamping rule from the start latency and the length. A closely spaced double edge shows whether a retrigger stretches the pulse while the scaler still counts both edges. A burst of nine edges, read back from a full-width bank and a three-bit bank, separates counting from saturation. An edge placed exactly on the snapshot cycle shows which period it lands in. OR, AND and empty-mask patterns with one or two active signals show that the mode bits are decoded correctly.

// File: rtl/disc_pkg.sv
package disc_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int WW        = 4;
  localparam int WMIN      = 2;
  localparam int WMAX      = 10;
  localparam logic [ADDR_W-1:0] A_WIDTH = 8'h00;
  localparam logic [ADDR_W-1:0] A_CMD   = 8'h01;
  localparam logic [ADDR_W-1:0] A_MASK  = 8'h10;
  localparam logic [ADDR_W-1:0] A_MODE  = 8'h20;
  localparam logic [ADDR_W-1:0] A_SCL   = 8'h40;
endpackage

// File: rtl/disc_edge_det.sv
module disc_edge_det #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] level_in,
  output logic [N-1:0] rise
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= level_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/disc_shaper.sv
module disc_shaper #(
  parameter int N  = 32,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  rise,
  input  logic [WW-1:0] width,
  output logic [N-1:0]  pulse
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic [WW-1:0] left_q;
    always_ff @(posedge clk) begin
      if (rst)               left_q <= '0;
      else if (left_q != '0) left_q <= left_q - 1'b1;
      else if (rise[i])      left_q <= width;
    end
    assign pulse[i] = (left_q != '0);
  end
endmodule

// File: rtl/disc_scaler_bank.sv
module disc_scaler_bank #(
  parameter int N  = 32,
  parameter int CW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         rise,
  input  logic                 snap,
  output logic [N-1:0][CW-1:0] snap_q
);
  localparam logic [CW-1:0] FULL = '1;

  for (genvar i = 0; i < N; i++) begin : g_scl
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q     <= '0;
        snap_q[i] <= '0;
      end else if (snap) begin
        snap_q[i] <= cnt_q;
        cnt_q     <= CW'(rise[i]);
      end else if (rise[i] && cnt_q != FULL) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/disc_logic_matrix.sv
module disc_logic_matrix #(
  parameter int N    = 32,
  parameter int NOUT = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N-1:0]           pulse,
  input  logic [NOUT-1:0][N-1:0] mask,
  input  logic [NOUT-1:0]        mode_and,
  output logic [NOUT-1:0]        out_q
);
  for (genvar k = 0; k < NOUT; k++) begin : g_out
    logic [N-1:0] hit;
    logic         term;
    assign hit  = pulse & mask[k];
    assign term = mode_and[k] ? ((mask[k] != '0) && (hit == mask[k])) : (|hit);
    always_ff @(posedge clk) begin
      if (rst) out_q[k] <= 1'b0;
      else     out_q[k] <= term;
    end
  end
endmodule

// File: rtl/disc_dual_thr.sv
module disc_dual_thr
  import disc_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int CNT_W = 32,
  parameter int NOUT  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCH-1:0]      cmp_lo,
  input  logic [NCH-1:0]      cmp_hi,
  output logic [2*NCH-1:0]    pulse_out,
  output logic [NOUT-1:0]     logic_out,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata
);
  localparam int NSIG = 2 * NCH;

  logic [NSIG-1:0]             sig_in, rise;
  logic [WW-1:0]               width_q, width_eff;
  logic [NOUT-1:0][NSIG-1:0]   mask_q;
  logic [NOUT-1:0]             mode_q;
  logic                        snap;
  logic [NSIG-1:0][CNT_W-1:0]  snap_q;
  logic [DATA_W-1:0]           rd_mux;

  assign sig_in = {cmp_hi, cmp_lo};
  assign snap   = bus_wr && (bus_addr == A_CMD) && bus_wdata[0];

  always_comb begin
    if (width_q < WW'(WMIN))      width_eff = WW'(WMIN);
    else if (width_q > WW'(WMAX)) width_eff = WW'(WMAX);
    else                          width_eff = width_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q <= WW'(WMIN);
      mask_q  <= '0;
      mode_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_WIDTH) width_q <= bus_wdata[WW-1:0];
      if (bus_addr == A_MODE)  mode_q  <= bus_wdata[NOUT-1:0];
      for (int k = 0; k < NOUT; k++)
        if (bus_addr == A_MASK + ADDR_W'(k)) mask_q[k] <= bus_wdata[NSIG-1:0];
    end
  end

  disc_edge_det #(.N(NSIG)) u_edge (
    .clk(clk), .rst(rst), .level_in(sig_in), .rise(rise)
  );

  disc_shaper #(.N(NSIG), .WW(WW)) u_shape (
    .clk(clk), .rst(rst), .rise(rise), .width(width_eff), .pulse(pulse_out)
  );

  disc_scaler_bank #(.N(NSIG), .CW(CNT_W)) u_scl (
    .clk(clk), .rst(rst), .rise(rise), .snap(snap), .snap_q(snap_q)
  );

  disc_logic_matrix #(.N(NSIG), .NOUT(NOUT)) u_lgc (
    .clk(clk), .rst(rst), .pulse(pulse_out), .mask(mask_q),
    .mode_and(mode_q), .out_q(logic_out)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_WIDTH) rd_mux = DATA_W'(width_q);
    if (bus_addr == A_MODE)  rd_mux = DATA_W'(mode_q);
    for (int k = 0; k < NOUT; k++)
      if (bus_addr == A_MASK + ADDR_W'(k)) rd_mux = DATA_W'(mask_q[k]);
    for (int i = 0; i < NSIG; i++)
      if (bus_addr == A_SCL + ADDR_W'(i)) rd_mux = DATA_W'(snap_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/disc_dual_thr_chk.sv
module disc_dual_thr_chk #(
  parameter int NCH  = 16,
  parameter int NOUT = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [NCH-1:0]   cmp_lo,
  input logic [NCH-1:0]   cmp_hi,
  input logic [2*NCH-1:0] pulse_out,
  input logic [NOUT-1:0]  logic_out
);
  localparam int NSIG = 2 * NCH;
  logic [NSIG-1:0] sig;
  assign sig = {cmp_hi, cmp_lo};

  for (genvar i = 0; i < NSIG; i++) begin : g_a
    logic [4:0] run_q;
    always_ff @(posedge clk) begin
      if (rst)               run_q <= '0;
      else if (!pulse_out[i]) run_q <= '0;
      else if (run_q != 5'd31) run_q <= run_q + 1'b1;
    end

    AST_PULSE_MIN_TWO: assert property (@(posedge clk) disable iff (rst)
      $rose(pulse_out[i]) |=> pulse_out[i]); // R3
    AST_PULSE_MAX_TEN: assert property (@(posedge clk) disable iff (rst)
      run_q <= 5'd10); // R3
    AST_PULSE_ORIGIN: assert property (@(posedge clk) disable iff (rst)
      $rose(pulse_out[i]) |-> $past(sig[i], 3)); // R2
  end

  AST_LOGIC_NEEDS_PULSE: assert property (@(posedge clk) disable iff (rst)
    !(|pulse_out) |=> (logic_out == '0)); // R8
endmodule

bind disc_dual_thr disc_dual_thr_chk #(.NCH(NCH), .NOUT(NOUT)) u_chk (
  .clk(clk), .rst(rst), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
  .pulse_out(pulse_out), .logic_out(logic_out)
);

// File: tb/disc_dual_thr_tb.sv
module disc_dual_thr_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] stim = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, rdata_sat;
  logic [31:0] pulse_out, pulse_sat;
  logic [15:0] logic_out, logic_sat;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  disc_dual_thr u_dut (
    .clk(clk), .rst(rst), .cmp_lo(stim[15:0]), .cmp_hi(stim[31:16]),
    .pulse_out(pulse_out), .logic_out(logic_out), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  disc_dual_thr #(.CNT_W(3)) u_sat (
    .clk(clk), .rst(rst), .cmp_lo(stim[15:0]), .cmp_hi(stim[31:16]),
    .pulse_out(pulse_sat), .logic_out(logic_sat), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_sat)
  );

  // {index[5:0], width written[3:0], expected length[3:0]}
  localparam logic [13:0] VEC [6] = '{
    {6'd0,  4'd0,  4'd2},
    {6'd5,  4'd1,  4'd2},
    {6'd16, 4'd4,  4'd4},
    {6'd21, 4'd7,  4'd7},
    {6'd31, 4'd10, 4'd10},
    {6'd9,  4'd15, 4'd10}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] ds);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; ds = rdata_sat;
  endtask

  task automatic measure(input int idx, input bit retrig, output int first,
                         output int len, output int others);
    bit fell = 1'b0;
    first = -1; len = 0; others = 0;
    stim[idx] = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (k == 2) stim[idx] = 1'b0;
      if (k == 4 && retrig) stim[idx] = 1'b1;
      if (k == 6) stim[idx] = 1'b0;
      if (pulse_out[idx]) begin
        if (first < 0) first = k;
        if (!fell) len++;
      end else if (first >= 0) fell = 1'b1;
      if ((pulse_out & ~(32'd1 << idx)) != '0) others++;
    end
  endtask

  task automatic lmeas(input logic [31:0] pat, input int k, output int first);
    first = -1;
    stim = pat;
    for (int j = 1; j <= 16; j++) begin
      @(negedge clk);
      if (j == 2) stim = '0;
      if (logic_out[k] && first < 0) first = j;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ds;
    int first, len, oth;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    check("R10 pulse_out after reset", pulse_out, 32'd0);
    check("R10 logic_out after reset", logic_out, 32'd0);
    rd(8'h00, d, ds); check("R3 width reset value", d, 32'd2);
    rd(8'h10, d, ds); check("R10 mask0 reset", d, 32'd0);
    rd(8'h40, d, ds); check("R10 snapshot reset", d, 32'd0);
    rd(8'h7F, d, ds); check("R9 unmapped read", d, 32'd0);

    // R1 R2 R3 table walk
    for (int v = 0; v < 6; v++) begin
      int idx;
      idx = int'(VEC[v][13:8]);
      wr(8'h00, 32'(VEC[v][7:4]));
      repeat (2) @(negedge clk);
      measure(idx, 1'b0, first, len, oth);
      check("R2 pulse start latency", 32'(first), 32'd3);
      check("R3 pulse length", 32'(len), 32'(VEC[v][3:0]));
      check("R1 no other index pulses", 32'(oth), 32'd0);
    end
    rd(8'h00, d, ds); check("R3 width readback raw", d, 32'd15);

    // R5 R6 scaler counting and saturation
    wr(8'h01, 32'd1);
    wr(8'h00, 32'd10);
    for (int n = 0; n < 9; n++) begin
      stim[3] = 1'b1; repeat (2) @(negedge clk);
      stim[3] = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (12) @(negedge clk);
    // R4 retrigger does not extend
    measure(20, 1'b1, first, len, oth);
    check("R4 retriggered pulse length", 32'(len), 32'd10);
    repeat (4) @(negedge clk);
    wr(8'h01, 32'd1);
    rd(8'h43, d, ds);
    check("R5 scaler counts nine edges", d, 32'd9);
    check("R6 narrow scaler saturates", ds, 32'd7);
    rd(8'h54, d, ds);
    check("R5 retrigger edges counted", d, 32'd2);
    rd(8'h53, d, ds);
    check("R1 high index of channel 3 untouched", d, 32'd0);

    // R7 clear and coincident edge
    stim[5] = 1'b1; repeat (2) @(negedge clk);
    stim[5] = 1'b0;
    wr(8'h01, 32'd1);
    rd(8'h45, d, ds); check("R7 snapshot before coincident edge", d, 32'd0);
    rd(8'h43, d, ds); check("R7 scaler cleared by snapshot", d, 32'd0);
    repeat (12) @(negedge clk);
    wr(8'h01, 32'd1);
    rd(8'h45, d, ds); check("R7 coincident edge in new period", d, 32'd1);

    // R8 programmable logic
    wr(8'h00, 32'd4);
    wr(8'h10, 32'h0002_0001);
    wr(8'h11, 32'h0001_0001);
    wr(8'h12, 32'h0);
    wr(8'h20, 32'h6);
    rd(8'h11, d, ds); check("R8 mask readback", d, 32'h0001_0001);
    lmeas(32'h0002_0000, 0, first); check("R8 OR output latency", 32'(first), 32'd4);
    repeat (6) @(negedge clk);
    lmeas(32'h0000_0001, 1, first); check("R8 AND with one input stays low", 32'(first), -32'sd1);
    repeat (6) @(negedge clk);
    lmeas(32'h0001_0001, 1, first); check("R8 AND with both inputs", 32'(first), 32'd4);
    repeat (6) @(negedge clk);
    lmeas(32'hFFFF_FFFF, 2, first); check("R8 empty mask AND stays low", 32'(first), -32'sd1);
    repeat (6) @(negedge clk);
    lmeas(32'h0000_0004, 0, first); check("R8 unselected signal ignored", 32'(first), -32'sd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule